// File: doc/BRIEF.md
# Banked RAM mapping controller

This block sits beside a small 8-bit CPU and selects which physical 64K RAM page, and which 16K bank inside it, serves each CPU memory cycle. The CPU sees four 16K windows. The block can map each window onto a bank of the base page or onto a bank of a second page.

Software picks the mapping by writing to an I/O port. A qualified write stores a 3-bit mode code in a register. That register is write-only; another device may share the port and answer reads. On every CPU memory cycle the block then rewrites the two top address lines to the chosen bank. It also routes the incoming column strobe to one of two RAM strobe outputs, one for the base page and one for the extra page.

Video fetches always use the base page with the address lines untouched. An external disable input lets an expansion device take over a CPU cycle. While it is high, neither internal strobe is asserted.

Top module: `bank_mapper`

## Requirements
- R1: On a rising clock edge where `ioWrN` is 0, `addr15In` is 0 and `ioData[7:6]` is 2'b11, the register takes `ioData[2:0]` as the new mode. Bits 5:3 are ignored. The new mode governs the outputs from the following cycle on.
- R2: A cycle with `ioWrN` high (for example an I/O read) never changes the mode, whatever the address and data.
- R3: A write with `addr15In` = 1, or with `ioData[7:6]` other than 2'b11, leaves the mode unchanged.
- R4: While `rstN` is low the mode is cleared to 0, even after a mode has been written. In mode 0 every window w = {addr15In, addr14In} maps to base bank w.
- R5: Mode 1 maps window 3 to extra-page bank 3. Windows 0 to 2 go to base banks 0 to 2.
- R6: Mode 2 maps every window w to extra-page bank w.
- R7: Mode 3 maps the windows as follows:
  - window 0 to base bank 0;
  - window 1 to base bank 3;
  - window 2 to base bank 2;
  - window 3 to extra-page bank 3.
- R8: Modes 4 to 7 map window 1 to extra-page bank b, where b = mode[1:0]. Windows 0, 2 and 3 go to base banks 0, 2 and 3.
- R9: When `cpuCycle` = 1 and `ramDisable` = 1, both `casBaseN` and `casExtraN` stay high. The bank is still driven on the address outputs.
- R10: When `cpuCycle` = 0 (a video fetch), the mode and `ramDisable` have no effect:
  - {`addr15Out`,`addr14Out`} equals {`addr15In`,`addr14In`};
  - `casExtraN` stays high;
  - `casBaseN` follows `casInN`.
- R11: The bank is driven on {`addr15Out`,`addr14Out`}.
  - Base page means `casBaseN` low; extra page means `casExtraN` low.
  - On an enabled cycle with `casInN` low, exactly one of the two strobes is low.
  - With `casInN` high, both strobes are high.
  - The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode register |
| rstN | input | 1 | Asynchronous active-low reset |
| ioWrN | input | 1 | Active-low I/O write qualifier |
| addr15In | input | 1 | CPU address bit 15 (port decode and window select) |
| addr14In | input | 1 | CPU address bit 14 (window select) |
| ioData | input | 8 | CPU data bus during I/O writes |
| cpuCycle | input | 1 | 1 = CPU memory cycle, 0 = video fetch |
| ramDisable | input | 1 | External request to keep internal RAM idle |
| casInN | input | 1 | Incoming active-low column strobe |
| addr14Out | output | 1 | Remapped address bit 14 |
| addr15Out | output | 1 | Remapped address bit 15 |
| casBaseN | output | 1 | Active-low column strobe, base page |
| casExtraN | output | 1 | Active-low column strobe, extra page |

## Verification
The address and strobe outputs are combinational functions of the inputs and the stored mode, so they are due in the same cycle as the stimulus. The bench drives each probe on the falling edge and samples 2 ns later, well before the next rising edge. A mode write is due one rising edge after it is presented. Each write task holds the write for exactly one rising edge and releases it at the next falling edge, before any probe reads the new mapping. An ignored write is judged the same way: the bench probes the mapping after that edge and expects the mode it had before.

// File: rtl/bank_mapper_pkg.sv
`timescale 1ns/1ps
package bank_mapper_pkg;

  localparam int BANK_W  = 2;
  localparam int NUM_WIN = 1 << BANK_W;
  localparam int MODE_W  = 3;

  // strobes handed from control to datapath
  typedef struct packed {
    logic              loadMode;
    logic [MODE_W-1:0] newMode;
    logic              cpuSide;
    logic              strobeGate;
  } mapCtl_t;

  typedef struct packed {
    logic              extraPage;
    logic [BANK_W-1:0] bank;
  } winMap_t;

  localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(NUM_WIN - 1);
  localparam logic [BANK_W-1:0] SWAP_WIN = BANK_W'(1);

  function automatic winMap_t mapWindow(input logic [MODE_W-1:0] mode,
                                        input logic [BANK_W-1:0] win);
    winMap_t r;
    r.extraPage = 1'b0;
    r.bank      = win;
    if (mode[MODE_W-1]) begin
      // only the second window moves, to an extra bank picked by the low bits
      if (win == SWAP_WIN) begin
        r.extraPage = 1'b1;
        r.bank      = mode[BANK_W-1:0];
      end
    end else begin
      unique case (mode[1:0])
        2'd0: r = '{extraPage: 1'b0, bank: win};
        2'd1: r.extraPage = (win == TOP_BANK);
        2'd2: r.extraPage = 1'b1;
        default: begin
          if (win == TOP_BANK) r.extraPage = 1'b1;
          else if (win == SWAP_WIN) r.bank = TOP_BANK;
        end
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/bank_mapper_ctrl.sv
`timescale 1ns/1ps
module bank_mapper_ctrl
  import bank_mapper_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              ioWrN,
  input  logic              addr15In,
  input  logic [DATA_W-1:0] ioData,
  input  logic              cpuCycle,
  input  logic              ramDisable,
  output mapCtl_t           ctl
);

  localparam int TAG_HI = DATA_W - 1;
  localparam int TAG_LO = DATA_W - 2;

  logic tagMatch;
  logic portHit;
  logic unusedPageBits;

  assign tagMatch = ioData[TAG_HI] & ioData[TAG_LO];
  assign portHit  = ~ioWrN & ~addr15In;

  // page-select bits sit between mode and tag; single-page build ignores them
  assign unusedPageBits = ^ioData[TAG_LO-1:MODE_W];

  always_comb begin
    ctl.loadMode   = portHit & tagMatch;
    ctl.newMode    = ioData[MODE_W-1:0];
    ctl.cpuSide    = cpuCycle;
    ctl.strobeGate = ~(cpuCycle & ramDisable);
  end

endmodule

// File: rtl/bank_mapper_dp.sv
`timescale 1ns/1ps
module bank_mapper_dp
  import bank_mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mapCtl_t           ctl,
  input  logic [BANK_W-1:0] winIn,
  input  logic              casInN,
  output logic [BANK_W-1:0] winOut,
  output logic              casBaseN,
  output logic              casExtraN,
  output logic [MODE_W-1:0] modeQ
);

  winMap_t winTable [NUM_WIN];
  winMap_t sel;
  logic    useExtra;
  logic    casLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             modeQ <= '0;
    else if (ctl.loadMode) modeQ <= ctl.newMode;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign winTable[w] = mapWindow(modeQ, BANK_W'(w));
  end

  assign sel       = winTable[winIn];
  assign useExtra  = ctl.cpuSide & sel.extraPage;
  assign winOut    = ctl.cpuSide ? sel.bank : winIn;
  assign casLive   = ~casInN & ctl.strobeGate;
  assign casBaseN  = ~(casLive & ~useExtra);
  assign casExtraN = ~(casLive & useExtra);

endmodule

// File: rtl/bank_mapper.sv
`timescale 1ns/1ps
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrN,
  input  logic              addr15In,
  input  logic              addr14In,
  input  logic [DATA_W-1:0] ioData,
  input  logic              cpuCycle,
  input  logic              ramDisable,
  input  logic              casInN,
  output logic              addr14Out,
  output logic              addr15Out,
  output logic              casBaseN,
  output logic              casExtraN
);

  mapCtl_t           ctl;
  logic [BANK_W-1:0] winOut;
  logic [MODE_W-1:0] modeNow;

  bank_mapper_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .ioWrN     (ioWrN),
    .addr15In  (addr15In),
    .ioData    (ioData),
    .cpuCycle  (cpuCycle),
    .ramDisable(ramDisable),
    .ctl       (ctl)
  );

  bank_mapper_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .winIn    ({addr15In, addr14In}),
    .casInN   (casInN),
    .winOut   (winOut),
    .casBaseN (casBaseN),
    .casExtraN(casExtraN),
    .modeQ    (modeNow)
  );

  assign {addr15Out, addr14Out} = winOut;

endmodule

// File: rtl/bank_mapper_chk.sv
`timescale 1ns/1ps
module bank_mapper_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ioWrN,
  input logic       addr15In,
  input logic       addr14In,
  input logic [7:0] ioData,
  input logic       cpuCycle,
  input logic       ramDisable,
  input logic       casInN,
  input logic       addr14Out,
  input logic       addr15Out,
  input logic       casBaseN,
  input logic       casExtraN,
  input logic [2:0] modeNow
);

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ioWrN && !addr15In && ioData[7:6] == 2'b11) |=> (modeNow == $past(ioData[2:0])));

  // R2
  read_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioWrN |=> $stable(modeNow));

  // R3
  unqual_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ioWrN && (addr15In || ioData[7:6] != 2'b11)) |=> $stable(modeNow));

  // R4
  mode0_identity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == 3'd0 && cpuCycle) |->
      ({addr15Out, addr14Out} == {addr15In, addr14In} && casExtraN));

  // R9
  ramdis_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuCycle && ramDisable) |-> (casBaseN && casExtraN));

  // R10
  video_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuCycle |->
      ({addr15Out, addr14Out} == {addr15In, addr14In} && casExtraN && casBaseN == casInN));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~casBaseN, ~casExtraN}) <= 1);

  // R11
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!casInN && !(cpuCycle && ramDisable)) |-> (casBaseN != casExtraN));

  // R11
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    casInN |-> (casBaseN && casExtraN));

endmodule

bind bank_mapper bank_mapper_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ioWrN     (ioWrN),
  .addr15In  (addr15In),
  .addr14In  (addr14In),
  .ioData    (ioData),
  .cpuCycle  (cpuCycle),
  .ramDisable(ramDisable),
  .casInN    (casInN),
  .addr14Out (addr14Out),
  .addr15Out (addr15Out),
  .casBaseN  (casBaseN),
  .casExtraN (casExtraN),
  .modeNow   (modeNow)
);

// File: tb/bank_mapper_bench.sv
`timescale 1ns/1ps
module bank_mapper_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       ioWrN;
  logic       addr15In;
  logic       addr14In;
  logic [7:0] ioData;
  logic       cpuCycle;
  logic       ramDisable;
  logic       casInN;
  logic       addr14Out;
  logic       addr15Out;
  logic       casBaseN;
  logic       casExtraN;

  int         vecs = 0;
  int         bad = 0;
  logic [2:0] expMode;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  bank_mapper u_bank_mapper (
    .clk(clk), .rstN(rstN), .ioWrN(ioWrN), .addr15In(addr15In), .addr14In(addr14In),
    .ioData(ioData), .cpuCycle(cpuCycle), .ramDisable(ramDisable), .casInN(casInN),
    .addr14Out(addr14Out), .addr15Out(addr15Out), .casBaseN(casBaseN), .casExtraN(casExtraN)
  );

  // reference: returns {extraPage, bank}
  function automatic logic [2:0] refMap(input logic [2:0] m, input logic [1:0] w);
    case (m)
      3'd0: return {1'b0, w};
      3'd1: return {(w == 2'd3), w};
      3'd2: return {1'b1, w};
      3'd3: begin
        case (w)
          2'd0: return 3'b0_00;
          2'd1: return 3'b0_11;
          2'd2: return 3'b0_10;
          default: return 3'b1_11;
        endcase
      end
      default: return (w == 2'd1) ? {1'b1, m[1:0]} : {1'b0, w};
    endcase
  endfunction

  // expected {casBaseN, casExtraN, addr15Out, addr14Out}
  function automatic logic [3:0] refObs(input logic [2:0] m, input logic [1:0] w,
                                        input bit cpu, input bit casN, input bit dis);
    logic [2:0] mp;
    logic       live;
    mp   = cpu ? refMap(m, w) : {1'b0, w};
    live = !casN && !(cpu && dis);
    return {!(live && !mp[2]), !(live && mp[2]), mp[1:0]};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] d, input bit a15, input bit wrN);
    @(negedge clk);
    ioWrN = wrN; addr15In = a15; ioData = d;
    @(negedge clk);
    ioWrN = 1'b1; addr15In = 1'b0; ioData = 8'h00;
  endtask

  task automatic probe(input string tag, input logic [1:0] w, input bit cpu,
                       input bit casN, input bit dis);
    @(negedge clk);
    {addr15In, addr14In} = w; cpuCycle = cpu; casInN = casN; ramDisable = dis;
    #2;
    chk(tag, {casBaseN, casExtraN, addr15Out, addr14Out}, refObs(expMode, w, cpu, casN, dis));
    casInN = 1'b1;
  endtask

  task automatic tReset();
    expMode = 3'd0;
    for (int w = 0; w < 4; w++) probe("R4 reset mode0", 2'(w), 1'b1, 1'b0, 1'b0);
  endtask

  task automatic tWalkModes();
    string tag;
    for (int m = 0; m < 8; m++) begin
      writeReg(8'hC0 | 8'(m) | 8'((7 - m) << 3), 1'b0, 1'b0);
      expMode = 3'(m);
      case (m)
        0: tag = "R1/R4 mode0";
        1: tag = "R1/R5 mode1";
        2: tag = "R1/R6 mode2";
        3: tag = "R1/R7 mode3";
        default: tag = "R1/R8 mode4-7";
      endcase
      for (int w = 0; w < 4; w++) begin
        probe(tag, 2'(w), 1'b1, 1'b0, 1'b0);
        probe("R11 strobe idle", 2'(w), 1'b1, 1'b1, 1'b0);
      end
    end
  endtask

  task automatic tReadIgnored();
    writeReg(8'hC2, 1'b0, 1'b0); expMode = 3'd2;
    writeReg(8'hC1, 1'b0, 1'b1);
    probe("R2 read ignored", 2'd0, 1'b1, 1'b0, 1'b0);
    writeReg(8'hC5, 1'b1, 1'b1);
    probe("R2 read ignored", 2'd1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic tUnqualified();
    writeReg(8'hC3, 1'b1, 1'b0);
    probe("R3 A15 high", 2'd1, 1'b1, 1'b0, 1'b0);
    writeReg(8'h83, 1'b0, 1'b0);
    probe("R3 tag 10", 2'd1, 1'b1, 1'b0, 1'b0);
    writeReg(8'h43, 1'b0, 1'b0);
    probe("R3 tag 01", 2'd0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic tRamDisable();
    writeReg(8'hC2, 1'b0, 1'b0); expMode = 3'd2;
    for (int w = 0; w < 4; w++) probe("R9 disable", 2'(w), 1'b1, 1'b0, 1'b1);
    writeReg(8'hC0, 1'b0, 1'b0); expMode = 3'd0;
    probe("R9 disable mode0", 2'd2, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic tVideo();
    writeReg(8'hC3, 1'b0, 1'b0); expMode = 3'd3;
    for (int w = 0; w < 4; w++) begin
      probe("R10 video", 2'(w), 1'b0, 1'b0, 1'b0);
      probe("R10 video dis", 2'(w), 1'b0, 1'b0, 1'b1);
    end
    writeReg(8'hC6, 1'b0, 1'b0); expMode = 3'd6;
    probe("R10 video mode6", 2'd1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tMidReset();
    writeReg(8'hC5, 1'b0, 1'b0); expMode = 3'd5;
    probe("R8 before reset", 2'd1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    expMode = 3'd0;
    probe("R4 after reset", 2'd1, 1'b1, 1'b0, 1'b0);
    probe("R4 after reset", 2'd3, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    rstN = 1'b0; ioWrN = 1'b1; addr15In = 1'b0; addr14In = 1'b0; ioData = 8'h00;
    cpuCycle = 1'b1; ramDisable = 1'b0; casInN = 1'b1; expMode = 3'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tWalkModes();
    tReadIgnored();
    tUnqualified();
    tRamDisable();
    tVideo();
    tMidReset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

endmodule